// File: doc/BRIEF.md
# Channel-Major Sample Word Packer

The block takes a parallel sample bus, one bit per channel, and turns it into a stream of wide words, each holding a run of consecutive samples from a single channel. Every channel collects one bit per accepted sample. When a group of `WORD_W` samples is complete, the block emits one word for each enabled channel, lowest channel index first, and moves on to the next group. Disabled channels take up no slot in the stream, so a group yields as many words as there are bits set in the enable mask that belongs to it.

Collection and emission overlap. A finished group moves into a drain bank while the capture bank fills with the next group. The input is stalled only when a group is about to complete and the drain bank still holds words of the previous group. A flush request closes a partly filled group early. Its unfilled upper bit positions read as zero, and the group drains like a full one.

Top module: `chan_word_packer`

## Requirements
- R1: After reset `word_valid` is 0 and `smp_ready` is 1.
- R2: Within a channel's word, bit k holds that channel's value in the k-th accepted sample of the group, with the first sample at bit 0.
- R3: A group emits one word for each channel set in its mask, in ascending channel order, and nothing for cleared channels.
- R4: The mask of a group is the value of `ch_enable` when the group's first sample is accepted. Later changes to `ch_enable` apply from the next group.
- R5: A one-cycle `flush` pulse with `smp_valid` low closes a non-empty partial group. Its bits from the fill count upward are zero. A flush on an empty group emits nothing.
- R6: While `word_valid` is 1 and `word_ready` is 0, `word_valid` stays 1 and `word_data` is unchanged in the next cycle.
- R7: When the sample that completes a group is offered while the drain bank still holds unsent words, `smp_ready` is 0 and that sample is held, not lost.
- R8: A group whose mask is all zeros emits no words, and the next group can complete without stalling.
- R9: Samples other than the group's last are accepted while the previous group is still draining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_data | input | NUM_CH | One sample, bit c is channel c |
| smp_valid | input | 1 | Sample present |
| smp_ready | output | 1 | Sample accepted this cycle when valid |
| ch_enable | input | NUM_CH | Channel enable mask, sampled at group start |
| flush | input | 1 | Close the current partial group (pulse with smp_valid low) |
| word_data | output | WORD_W | Packed word of one channel |
| word_valid | output | 1 | Output word present |
| word_ready | input | 1 | Sink takes the word this cycle |

## Verification
The bench builds the packer with four channels and eight-bit words. All sixteen masks can then be swept, each under continuous, alternating and pseudo-random sink readiness, and a group completes in eight samples, so the stall at a group's last sample and its overlap with draining show up within a few cycles. The small width also allows partial flushes at several fill counts and mask changes in the middle of a group, with every expected word computed in the bench from the sample pattern.

// File: rtl/cwp_pkg.sv
package cwp_pkg;
  // Index of the lowest set bit; 0 when none is set.
  function automatic int lowest_set(input logic [31:0] m);
    int idx;
    idx = 0;
    for (int i = 31; i >= 0; i--) begin
      if (m[i]) idx = i;
    end
    return idx;
  endfunction
endpackage

// File: rtl/cwp_capture.sv
module cwp_capture #(
  parameter int NUM_CH = 16,
  parameter int WORD_W = 64,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_CH-1:0]              smp_data,
  input  logic                           smp_valid,
  output logic                           smp_ready,
  input  logic [NUM_CH-1:0]              ch_enable,
  input  logic                           flush,
  input  logic                           bank_free,
  output logic                           grp_load,
  output logic [NUM_CH-1:0][WORD_W-1:0]  grp_words,
  output logic [NUM_CH-1:0]              grp_mask
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [NUM_CH-1:0][WORD_W-1:0] cap_q;
  logic [CNT_W-1:0]              cnt_q;
  logic [NUM_CH-1:0]             mask_q;
  logic                          flush_pend_q;
  logic                          flush_req, accept, close_full, close_part;

  assign flush_req  = flush | flush_pend_q;
  assign smp_ready  = !flush_req && ((cnt_q != LAST) || bank_free);
  assign accept     = smp_valid && smp_ready;
  assign close_full = accept && (cnt_q == LAST);
  assign close_part = flush_req && (cnt_q != '0) && bank_free;
  assign grp_load   = close_full || close_part;
  assign grp_mask   = (cnt_q == '0) ? ch_enable : mask_q;

  always_comb begin
    grp_words = cap_q;
    if (accept) begin
      for (int c = 0; c < NUM_CH; c++) grp_words[c][cnt_q] = smp_data[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q        <= '0;
      cnt_q        <= '0;
      mask_q       <= '0;
      flush_pend_q <= 1'b0;
    end else begin
      flush_pend_q <= flush_req && (cnt_q != '0) && !bank_free;
      if (accept && cnt_q == '0) mask_q <= ch_enable;
      if (grp_load) begin
        cap_q <= '0;
        cnt_q <= '0;
      end else if (accept) begin
        cap_q <= grp_words;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // A partial close always leaves an empty capture bank behind.
  assert_flush_empties_R5: assert property (@(posedge clk) disable iff (rst)
    close_part |=> (cnt_q == '0) && (cap_q == '0));

  // A group never completes into a bank that is still draining.
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    grp_load |-> bank_free);
endmodule

// File: rtl/cwp_drain.sv
module cwp_drain
  import cwp_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int WORD_W = 64
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           grp_load,
  input  logic [NUM_CH-1:0][WORD_W-1:0]  grp_words,
  input  logic [NUM_CH-1:0]              grp_mask,
  output logic                           bank_free,
  output logic [WORD_W-1:0]              word_data,
  output logic                           word_valid,
  input  logic                           word_ready
);
  logic [NUM_CH-1:0][WORD_W-1:0] bank_q;
  logic [NUM_CH-1:0]             rem_q;
  logic [WORD_W-1:0]             od_q;
  logic                          ov_q;
  logic                          advance, take;
  int                            pick;

  assign bank_free  = (rem_q == '0);
  assign advance    = !ov_q || word_ready;
  assign take       = advance && (rem_q != '0);
  assign pick       = lowest_set(32'(rem_q));
  assign word_data  = od_q;
  assign word_valid = ov_q;

  always_ff @(posedge clk) begin
    if (grp_load) bank_q <= grp_words;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      ov_q  <= 1'b0;
      od_q  <= '0;
    end else begin
      if (grp_load) begin
        rem_q <= grp_mask;
      end else if (take) begin
        rem_q[pick] <= 1'b0;
      end
      if (advance) begin
        ov_q <= take;
        if (take) od_q <= bank_q[pick];
      end
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> !ov_q && (rem_q == '0));

  assert_one_word_per_channel_R3: assert property (@(posedge clk) disable iff (rst)
    take |=> $countones(rem_q) == $countones($past(rem_q)) - 1);

  assert_empty_mask_R8: assert property (@(posedge clk) disable iff (rst)
    grp_load && (grp_mask == '0) |=> bank_free);

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    ov_q && !word_ready |=> ov_q && $stable(od_q));
endmodule

// File: rtl/chan_word_packer.sv
module chan_word_packer #(
  parameter int NUM_CH = 16,
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] smp_data,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [NUM_CH-1:0] ch_enable,
  input  logic              flush,
  output logic [WORD_W-1:0] word_data,
  output logic              word_valid,
  input  logic              word_ready
);
  logic                          bank_free, grp_load;
  logic [NUM_CH-1:0][WORD_W-1:0] grp_words;
  logic [NUM_CH-1:0]             grp_mask;

  cwp_capture #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_capture (
    .clk(clk), .rst(rst), .smp_data(smp_data), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .ch_enable(ch_enable), .flush(flush),
    .bank_free(bank_free), .grp_load(grp_load), .grp_words(grp_words),
    .grp_mask(grp_mask)
  );

  cwp_drain #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_drain (
    .clk(clk), .rst(rst), .grp_load(grp_load), .grp_words(grp_words),
    .grp_mask(grp_mask), .bank_free(bank_free), .word_data(word_data),
    .word_valid(word_valid), .word_ready(word_ready)
  );
endmodule

// File: tb/chan_word_packer_tb.sv
module chan_word_packer_tb;
  localparam int NUM_CH = 4;
  localparam int WORD_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NUM_CH-1:0] smp_data = '0;
  logic              smp_valid = 1'b0;
  logic              smp_ready;
  logic [NUM_CH-1:0] ch_enable = '0;
  logic              flush = 1'b0;
  logic [WORD_W-1:0] word_data;
  logic              word_valid;
  logic              word_ready = 1'b0;

  chan_word_packer #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_dut (
    .clk(clk), .rst(rst), .smp_data(smp_data), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .ch_enable(ch_enable), .flush(flush),
    .word_data(word_data), .word_valid(word_valid), .word_ready(word_ready)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int rdy_mode = 0;
  logic [7:0] lfsr = 8'h5B;

  logic [WORD_W-1:0] exp_mem [0:1023];
  string             exp_tag [0:1023];
  int wp = 0, rp = 0;

  logic [WORD_W-1:0] m_cap [NUM_CH];
  int                m_cnt = 0;
  logic [NUM_CH-1:0] m_mask = '0;
  string             cur_tag = "R3";

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_close();
    for (int c = 0; c < NUM_CH; c++) begin
      if (m_mask[c]) begin
        exp_mem[wp % 1024] = m_cap[c];
        exp_tag[wp % 1024] = cur_tag;
        wp++;
      end
      m_cap[c] = '0;
    end
    m_cnt = 0;
  endtask

  task automatic model_accept(input logic [NUM_CH-1:0] d);
    if (m_cnt == 0) m_mask = ch_enable;
    for (int c = 0; c < NUM_CH; c++) m_cap[c][m_cnt] = d[c];
    m_cnt++;
    if (m_cnt == WORD_W) model_close();
  endtask

  // Offer one sample; returns the number of cycles it waited for acceptance.
  task automatic send(input logic [NUM_CH-1:0] d, output int waited);
    waited = 0;
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = d;
    forever begin
      automatic logic r = smp_ready;
      @(posedge clk);
      if (r) break;
      waited++;
      @(negedge clk);
    end
    model_accept(d);
    #1 smp_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    smp_valid = 1'b0;
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    if (m_cnt > 0) model_close();
  endtask

  task automatic wait_drained(input string tag);
    int t = 0;
    while ((rp != wp || word_valid) && t < 2000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    check(rp == wp && !word_valid, tag, rp, wp);
  endtask

  // Sink: pick readiness, then compare any word the coming edge will take.
  always @(negedge clk) begin
    automatic logic r;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (rdy_mode)
      0: r = 1'b1;
      1: r = ~word_ready;
      2: r = lfsr[0];
      default: r = 1'b0;
    endcase
    if (!rst && word_valid && r) begin
      if (rp == wp) begin
        check(1'b0, "R3 unexpected word", word_data, 0);
      end else begin
        check(word_data == exp_mem[rp % 1024], exp_tag[rp % 1024], word_data, exp_mem[rp % 1024]);
        rp++;
      end
    end
    word_ready = r;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int w;
    for (int c = 0; c < NUM_CH; c++) m_cap[c] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(smp_ready == 1'b1, "R1 smp_ready", smp_ready, 1);
    check(word_valid == 1'b0, "R1 word_valid", word_valid, 0);

    // R2 R3 R8: every mask under three sink patterns, two groups each.
    for (int mode = 0; mode < 3; mode++) begin
      rdy_mode = mode;
      for (int mk = 0; mk < 16; mk++) begin
        cur_tag = (mk == 0) ? "R8" : "R2/R3";
        ch_enable = NUM_CH'(mk);
        for (int g = 0; g < 2; g++)
          for (int n = 0; n < WORD_W; n++)
            send(NUM_CH'(n * 5 + g * 3 + mk + mode * 7), w);
      end
      wait_drained("R3 drain count");
    end

    // R8: all-zero group directly before a full one completes without stall.
    rdy_mode = 3;
    cur_tag = "R8";
    ch_enable = '0;
    for (int n = 0; n < WORD_W; n++) send(NUM_CH'(n), w);
    ch_enable = 4'hF;
    for (int n = 0; n < WORD_W; n++) begin
      send(NUM_CH'(n + 9), w);
      if (n == WORD_W - 1) check(w == 0, "R8 no stall after empty group", w, 0);
    end

    // R9 then R7: previous group still draining with the sink stopped.
    cur_tag = "R7/R9";
    for (int n = 0; n < WORD_W - 1; n++) begin
      send(NUM_CH'(n * 3 + 1), w);
      check(w == 0, "R9 accept while draining", w, 0);
    end
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = 4'hA;
    #1 check(smp_ready == 1'b0, "R7 stall last sample", smp_ready, 0);
    repeat (3) @(negedge clk);
    check(smp_ready == 1'b0, "R7 still stalled", smp_ready, 0);
    smp_valid = 1'b0;
    rdy_mode = 0;
    send(4'hA, w);
    check(w > 0, "R7 held then taken", w, 1);
    wait_drained("R7 no sample lost");

    // R4: mask change inside a group.
    cur_tag = "R4";
    for (int mode = 0; mode < 3; mode++) begin
      rdy_mode = mode;
      ch_enable = 4'b0101;
      send(4'hF, w);
      ch_enable = 4'b1010;
      for (int n = 1; n < WORD_W; n++) send(NUM_CH'(n * 7), w);
      for (int n = 0; n < WORD_W; n++) send(NUM_CH'(n + mode), w);
      wait_drained("R4 word count");
    end

    // R5: partial flushes at every fill count, and a flush on an empty group.
    cur_tag = "R5";
    ch_enable = 4'b1011;
    for (int fill = 1; fill < WORD_W; fill++) begin
      rdy_mode = fill % 3;
      for (int n = 0; n < fill; n++) send(NUM_CH'(n * 11 + fill), w);
      do_flush();
    end
    rdy_mode = 0;
    wait_drained("R5 partial groups");
    do_flush();
    repeat (6) @(negedge clk);
    check(!word_valid && rp == wp, "R5 empty flush emits nothing", word_valid, 0);
    // Flush while the drain bank is busy: request held until it frees.
    rdy_mode = 3;
    for (int n = 0; n < WORD_W; n++) send(NUM_CH'(n), w);
    for (int n = 0; n < 3; n++) send(NUM_CH'(n + 5), w);
    do_flush();
    repeat (3) @(negedge clk);
    rdy_mode = 0;
    wait_drained("R5 pending flush");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule